// File: doc/BRIEF.md
# Dual-Rail Four-Phase Pipeline Register Stage

This block is one register stage in a pipeline of dual-rail, delay-insensitive logic. It holds a word of `WIDTH` bits and uses a four-phase handshake with both neighbours. Each bit travels as a pair of rails, a true rail and a false rail. When both rails are low the bit is empty (a spacer). When exactly one rail is high the bit carries a value. The stage lets a wavefront through only when the downstream stage asks for that kind of wavefront. It reports its own completion upstream as a request for the opposite kind.

The stage has no clock enable and no load strobe. Storage and flow control come from hysteretic two-input threshold gates, one per output rail. Each gate combines the incoming rail with the downstream request. Completion is found by OR-ing the two rails of every bit and passing the results through a hysteretic all-of-N gate. The threshold gates are emulated as flip-flops on a free-running clock, so the stage can be synthesized. Each gate stage therefore costs one clock cycle.

A whole transaction runs in four steps. The stage receives a spacer, asks for a value, receives a value, asks for a spacer, and then starts again.

Top module: `dr_reg_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output rail becomes 0 and `rqst_to_prev` becomes 1, whatever the other inputs are.
- R2: The pair {`dout_t[i]`, `dout_f[i]`} is decoded as follows: 00 is empty, 10 is value 1, and 01 is value 0. Given legal inputs, the pair 11 never appears.
- R3: An output rail goes to 1 one clock after its input rail and `rqst_from_next` are both 1.
- R4: An output rail goes to 0 one clock after its input rail and `rqst_from_next` are both 0.
- R5: An output rail keeps its value while its input rail and `rqst_from_next` differ. A value that arrives while an empty word is requested is not passed on. An empty word that arrives while a value is requested does not erase the held value.
- R6: `rqst_to_prev` goes to 0 one clock after every output pair holds a value. It goes to 1 one clock after every output pair is empty. With a mix of empty and valued pairs it keeps its value.
- R7: Under a producer and a consumer with random response delays, words leave the stage in the order they entered, with none lost and none duplicated.
- R8: An output pair never moves directly from one value code to the other. It passes through empty first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock for the threshold gates |
| rst_n | input | 1 | Synchronous active-low reset |
| din_t | input | WIDTH | True rails of the incoming word |
| din_f | input | WIDTH | False rails of the incoming word |
| rqst_from_next | input | 1 | Downstream request: 1 asks for a value, 0 asks for empty |
| dout_t | output | WIDTH | True rails of the held word |
| dout_f | output | WIDTH | False rails of the held word |
| rqst_to_prev | output | 1 | Upstream request: 1 asks for a value, 0 asks for empty |

## Verification
The assertions assume that no input pair is ever driven to 11. They also assume the upstream neighbour obeys `rqst_to_prev`: it changes a pair from empty to a value only while a value is requested, and changes it back only while an empty word is requested. The producer model follows these rules, although it lets bits of a wavefront arrive over several cycles in a random split. The directed part deliberately breaks the handshake in ways that stay legal rail-wise. It presents a value while an empty word is requested and an empty word while a value is held, to show that the gates block these changes. The consumer changes `rqst_from_next` only after it sees a complete wavefront.

// File: rtl/dr_reg_pkg.sv
// Package: dual-rail pair helpers shared by the register stage modules.
// Assumes the true rail is listed first and the false rail second.
package dr_reg_pkg;

    // Report whether a rail pair carries a value (either rail high).
    function automatic logic pair_has_value(logic rail_t, logic rail_f);
        return rail_t | rail_f;
    endfunction

    // Report whether a rail pair is in the illegal both-high state.
    function automatic logic pair_is_bad(logic rail_t, logic rail_f);
        return rail_t & rail_f;
    endfunction

endpackage

// File: rtl/dr_th22.sv
// Module: dr_th22
// Emulates a hysteretic two-of-two threshold gate as a flip-flop.
// The output sets when both inputs are high, clears when both are low,
// and holds otherwise. Assumes inputs are stable relative to clk.
module dr_th22 (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q
);

    // Gate state update with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (a && b)
            q <= 1'b1;
        else if (!a && !b)
            q <= 1'b0;
    end

    // R3
    rise_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> ($past(a) && $past(b)));

    // R4
    fall_needs_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> (!$past(a) && !$past(b)));

    // R5
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(a) != $past(b))) |-> $stable(q));

endmodule

// File: rtl/dr_completion.sv
// Module: dr_completion
// Completion detector for a dual-rail word. Each pair is ORed, then an
// all-of-WIDTH hysteretic gate (emulated as a flop) combines the bits.
// all_valued sets when every pair holds a value, clears when every pair
// is empty, and holds on a mix. Assumes no pair is ever 11.
module dr_completion
    import dr_reg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             all_valued
);

    localparam logic [WIDTH-1:0] ALL_SET = {WIDTH{1'b1}};

    logic [WIDTH-1:0] bit_valued;

    // Per-bit OR of the two rails.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit_or
        assign bit_valued[i] = pair_has_value(rail_t[i], rail_f[i]);
    end

    // All-of-N hysteretic threshold gate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            all_valued <= 1'b0;
        else if (bit_valued == ALL_SET)
            all_valued <= 1'b1;
        else if (bit_valued == '0)
            all_valued <= 1'b0;
    end

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_valued) |-> ($past(rail_t | rail_f) == ALL_SET));

    // R6
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(all_valued) |-> ($past(rail_t | rail_f) == '0));

    // R6
    done_mixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(rail_t | rail_f) != ALL_SET)
                      && ($past(rail_t | rail_f) != '0)) |-> $stable(all_valued));

endmodule

// File: rtl/dr_reg_stage.sv
// Module: dr_reg_stage
// Four-phase dual-rail register stage. Each output rail is a two-of-two
// hysteretic gate of its input rail and the downstream request, so a
// wavefront passes only when the downstream stage asks for its kind.
// The upstream request is the inverse of the stage's own completion.
// Assumes the neighbours keep to the four-phase protocol and never
// drive a pair to 11.
module dr_reg_stage
    import dr_reg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_t,
    input  logic [WIDTH-1:0] din_f,
    input  logic             rqst_from_next,
    output logic [WIDTH-1:0] dout_t,
    output logic [WIDTH-1:0] dout_f,
    output logic             rqst_to_prev
);

    logic stage_done;

    // Storage gates: one pair of threshold gates per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dr_th22 u_gate_t (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (din_t[i]),
            .b     (rqst_from_next),
            .q     (dout_t[i])
        );
        dr_th22 u_gate_f (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (din_f[i]),
            .b     (rqst_from_next),
            .q     (dout_f[i])
        );

        // R2
        no_bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pair_is_bad(dout_t[i], dout_f[i]));

        // R8
        no_value_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dout_t[i]) |-> !dout_f[i]) and ($past(dout_f[i]) |-> !dout_t[i]));
    end

    // Completion detection over the held word.
    dr_completion #(.WIDTH(WIDTH)) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_t     (dout_t),
        .rail_f     (dout_f),
        .all_valued (stage_done)
    );

    // Upstream request is the inverted completion.
    assign rqst_to_prev = ~stage_done;

endmodule

// File: tb/tb_dr_reg_stage.sv
module tb_dr_reg_stage;

    localparam int W = 8;
    localparam int NWORDS = 150;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din_t = '0;
    logic [W-1:0] din_f = '0;
    logic         rqst_from_next = 1'b0;
    logic [W-1:0] dout_t;
    logic [W-1:0] dout_f;
    logic         rqst_to_prev;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    logic [W-1:0] exp_q[$];

    always #4 clk = ~clk;

    dr_reg_stage #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .din_t(din_t), .din_f(din_f),
        .rqst_from_next(rqst_from_next), .dout_t(dout_t), .dout_f(dout_f),
        .rqst_to_prev(rqst_to_prev)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // Protocol monitor on every sample point.
    initial begin
        logic [W-1:0] pt = '0;
        logic [W-1:0] pf = '0;
        forever begin
            tick(1);
            if (mon_on) begin
                bit ok = 1'b1;
                for (int i = 0; i < W; i++) begin
                    bit was_v = pt[i] | pf[i];
                    bit now_v = dout_t[i] | dout_f[i];
                    if (dout_t[i] & dout_f[i]) ok = 1'b0;                       // R2
                    if (!was_v && now_v && !rqst_from_next) ok = 1'b0;          // R3
                    if (was_v && !now_v && rqst_from_next) ok = 1'b0;           // R4
                    if ((pt[i] && dout_f[i]) || (pf[i] && dout_t[i])) ok = 1'b0; // R8
                end
                check(ok, "R2/R3/R4/R8 protocol", {dout_t, dout_f}, {pt, pf});
            end
            pt = dout_t;
            pf = dout_f;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic producer();
        for (int w = 0; w < NWORDS; w++) begin
            logic [W-1:0] word = W'($urandom);
            logic [W-1:0] mask = W'($urandom);
            logic [W-1:0] nmask = W'($urandom);
            while (rqst_to_prev !== 1'b1) tick(1);
            @(negedge clk);
            exp_q.push_back(word);
            din_t = word & mask;
            din_f = ~word & mask;
            repeat ($urandom % 3) @(negedge clk);
            @(negedge clk);
            din_t = word;
            din_f = ~word;
            tick(1);
            while (rqst_to_prev !== 1'b0) tick(1);
            repeat ($urandom % 3) @(negedge clk);
            @(negedge clk);
            din_t = din_t & nmask;
            din_f = din_f & nmask;
            repeat ($urandom % 3) @(negedge clk);
            @(negedge clk);
            din_t = '0;
            din_f = '0;
        end
    endtask

    task automatic consumer();
        for (int w = 0; w < NWORDS; w++) begin
            logic [W-1:0] expv;
            while ((dout_t | dout_f) !== '1) tick(1);
            repeat ($urandom % 4) tick(1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected word", 32'(dout_t), 32'hx);
            end else begin
                expv = exp_q.pop_front();
                check(dout_t === expv && dout_f === ~expv, "R7 order", 32'(dout_t), 32'(expv));
            end
            @(negedge clk);
            rqst_from_next = 1'b0;
            tick(1);
            while ((dout_t | dout_f) !== '0) tick(1);
            repeat ($urandom % 4) tick(1);
            @(negedge clk);
            rqst_from_next = 1'b1;
        end
    endtask

    initial begin
        // R1: reset overrides legal-looking inputs
        din_t = 8'hA5; din_f = 8'h5A; rqst_from_next = 1'b1;
        tick(3);
        check(dout_t === '0 && dout_f === '0, "R1 rails", {dout_t, dout_f}, 0);
        check(rqst_to_prev === 1'b1, "R1 request", 32'(rqst_to_prev), 1);
        @(negedge clk);
        rst_n = 1'b1; din_t = '0; din_f = '0; rqst_from_next = 1'b0;
        tick(2);
        mon_on = 1'b1;

        // R5: value blocked while empty is requested
        @(negedge clk);
        din_t = 8'h3C; din_f = 8'hC3;
        tick(4);
        check(dout_t === '0 && dout_f === '0, "R5 blocked value", {dout_t, dout_f}, 0);
        check(rqst_to_prev === 1'b1, "R6 idle request", 32'(rqst_to_prev), 1);

        // R3: value passes one clock after request rises
        @(negedge clk);
        rqst_from_next = 1'b1;
        tick(1);
        check(dout_t === 8'h3C && dout_f === 8'hC3, "R3 pass", {dout_t, dout_f}, 16'h3CC3);
        check(rqst_to_prev === 1'b1, "R6 not yet", 32'(rqst_to_prev), 1);
        tick(1);
        check(rqst_to_prev === 1'b0, "R6 complete", 32'(rqst_to_prev), 0);

        // R5: empty input does not erase held value
        @(negedge clk);
        din_t = '0; din_f = '0;
        tick(3);
        check(dout_t === 8'h3C && dout_f === 8'hC3, "R5 held value", {dout_t, dout_f}, 16'h3CC3);

        // R4: clears one clock after request falls
        @(negedge clk);
        rqst_from_next = 1'b0;
        tick(1);
        check(dout_t === '0 && dout_f === '0, "R4 clear", {dout_t, dout_f}, 0);
        tick(1);
        check(rqst_to_prev === 1'b1, "R6 empty", 32'(rqst_to_prev), 1);

        // R6: partial value keeps request high
        @(negedge clk);
        rqst_from_next = 1'b1; din_t = 8'h05; din_f = 8'h0A;
        tick(3);
        check(dout_t === 8'h05 && dout_f === 8'h0A, "R3 partial", {dout_t, dout_f}, 16'h050A);
        check(rqst_to_prev === 1'b1, "R6 partial value hold", 32'(rqst_to_prev), 1);
        @(negedge clk);
        din_t = 8'h95; din_f = 8'h6A;
        tick(2);
        check(rqst_to_prev === 1'b0, "R6 full value", 32'(rqst_to_prev), 0);

        // R6: partial empty keeps request low
        @(negedge clk);
        rqst_from_next = 1'b0; din_t = 8'h90; din_f = 8'h60;
        tick(3);
        check(dout_t === 8'h90 && dout_f === 8'h60, "R4 partial", {dout_t, dout_f}, 16'h9060);
        check(rqst_to_prev === 1'b0, "R6 partial empty hold", 32'(rqst_to_prev), 0);
        @(negedge clk);
        din_t = '0; din_f = '0;
        tick(2);
        check(rqst_to_prev === 1'b1, "R6 all empty", 32'(rqst_to_prev), 1);

        // R7: random producer and consumer
        @(negedge clk);
        rqst_from_next = 1'b1;
        fork
            producer();
            consumer();
        join
        check(exp_q.size() == 0, "R7 leftover words", 32'(exp_q.size()), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule